// File: doc/BRIEF.md
# Boundary-Scan Register with Per-Driver Control Cells

This block is the 65-cell serial boundary-scan register that sits between core logic and device pins. A test access controller drives its capture, shift and update strobes, a test-mode select and a global driver-off request. Every cell has a capture/shift stage and an update stage. Cells that watch input pins only observe. Cells on output and bidirectional pins can take over the pin data. Each driven pin also has its own control cell, which sits directly after its data cell and can take over the driver enable.

In normal mode the pins follow the core. In test mode they follow the update stages, with a control value of 1 turning the driver off. The global driver-off request overrides every enable. A handful of cells carry no pin and only pass scan data along. The controller's state machine and the pads themselves lie outside this block.

Top module: `bsr_chain`

## Requirements
- R1: The chain holds 65 cells. `tdo_o` shows cell 0, and `tdi_i` enters cell 64. On each `shift_i` edge (with `capture_i` low) every cell takes its neighbour's value one position nearer TDI. After 65 shifts, the k-th bit shifted in (k = 0 first) sits in cell k.
- R2: Cells 0, 9, 34, 39 and 55 have no pin and capture 0.
- R3: Observe cells sit at positions 1, 2, 14, 29, 30, 33, 44, 62, 63, 64, which map to `in_pin_i` bits 0..9 in that order. Each captures its pin. `in_core_o` always equals `in_pin_i`.
- R4: Output cells sit at positions 3, 31, 35, 37, 40, 42, 56, 58, which map to output bits 0..7. Each captures the value present on `out_pin_d_o`.
- R5: Bidirectional cells sit at positions 5, 7, 10, 12, 15, 17, 19, 21, 23, 25, 27, 45, 47, 49, 51, 53, 60, which map to bidirectional bits 0..16. Each captures the sensed pin `bid_pin_i`. `bid_core_o` always equals `bid_pin_i`.
- R6: A driver whose data cell is at position n has its control cell at n+1. The control cell captures 1 when that pin's enable output is off and 0 when it is on.
- R7: With `test_mode_i`=0 and `hiz_i`=0, every pin data and enable output equals its core-side data and enable.
- R8: With `test_mode_i`=1, pin data equals the update stage of cell n. The enable is the inverse of the update stage of cell n+1, so 1 means the driver is off.
- R9: `hiz_i`=1 forces every enable output to 0 in both modes and leaves the data outputs unchanged.
- R10: Update stages load only on an edge where `update_i` is high. Shift and capture edges leave all pin outputs unchanged.
- R11: Reset (`rst_ni`=0) sets both stages of every control cell to 1 and both stages of every other cell to 0. As a result, test mode after reset drives no pin and reads data 0.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| capture_i | input | 1 | Load all capture stages on the next edge |
| shift_i | input | 1 | Shift the chain by one toward `tdo_o` |
| update_i | input | 1 | Copy capture stages into update stages |
| test_mode_i | input | 1 | 1: pins driven from update stages |
| hiz_i | input | 1 | Global driver-off request |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out (cell 0) |
| in_pin_i | input | 10 | Input-only pin values |
| in_core_o | output | 10 | Input pin values passed to core |
| out_core_d_i | input | 8 | Core data for output pins |
| out_core_oe_i | input | 8 | Core enable for output pins, 1 drives |
| out_pin_d_o | output | 8 | Data to output pins |
| out_pin_oe_o | output | 8 | Enable to output pins, 1 drives |
| bid_core_d_i | input | 17 | Core data for bidirectional pins |
| bid_core_oe_i | input | 17 | Core enable for bidirectional pins |
| bid_pin_i | input | 17 | Sensed bidirectional pin values |
| bid_core_o | output | 17 | Sensed bidirectional values to core |
| bid_pin_d_o | output | 17 | Data to bidirectional pins |
| bid_pin_oe_o | output | 17 | Enable to bidirectional pins, 1 drives |

## Verification
Random pin and core vectors are captured and scanned out in normal mode, with and without the global off request. This separates the five cell kinds, checks where each position sits, and shows whether the control cells read the enable at the pin or the core request. Random 65-bit words are shifted in and read back to fix the chain length and direction. In test mode, random words are loaded and the pins are checked before and after each update strobe. That shows whether data and control pairs are offset by one, whether shifting leaks onto the pins, and how the control value is polarised. The reset scan-out and the pin state during reset pin down the safe values.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  typedef enum logic [2:0] {CK_INT, CK_IN, CK_OUT, CK_BID, CK_CTL} cell_kind_e;

  typedef struct packed {
    cell_kind_e  kind;
    logic [4:0]  len;
  } run_t;

  localparam int NUM_RUNS = 21;

  // Pin groups in chain order from cell 0; each driven pin expands to data+control.
  function automatic run_t run_at(int r);
    run_t v;
    case (r)
      0:  v = '{kind: CK_INT, len: 5'd1};
      1:  v = '{kind: CK_IN,  len: 5'd2};
      2:  v = '{kind: CK_OUT, len: 5'd1};
      3:  v = '{kind: CK_BID, len: 5'd2};
      4:  v = '{kind: CK_INT, len: 5'd1};
      5:  v = '{kind: CK_BID, len: 5'd2};
      6:  v = '{kind: CK_IN,  len: 5'd1};
      7:  v = '{kind: CK_BID, len: 5'd7};
      8:  v = '{kind: CK_IN,  len: 5'd2};
      9:  v = '{kind: CK_OUT, len: 5'd1};
      10: v = '{kind: CK_IN,  len: 5'd1};
      11: v = '{kind: CK_INT, len: 5'd1};
      12: v = '{kind: CK_OUT, len: 5'd2};
      13: v = '{kind: CK_INT, len: 5'd1};
      14: v = '{kind: CK_OUT, len: 5'd2};
      15: v = '{kind: CK_IN,  len: 5'd1};
      16: v = '{kind: CK_BID, len: 5'd5};
      17: v = '{kind: CK_INT, len: 5'd1};
      18: v = '{kind: CK_OUT, len: 5'd2};
      19: v = '{kind: CK_BID, len: 5'd1};
      20: v = '{kind: CK_IN,  len: 5'd3};
      default: v = '{kind: CK_INT, len: 5'd0};
    endcase
    return v;
  endfunction

  function automatic cell_kind_e kind_at(int c);
    cell_kind_e k;
    int pos;
    run_t rr;
    k = CK_INT;
    pos = 0;
    for (int r = 0; r < NUM_RUNS; r++) begin
      rr = run_at(r);
      for (int i = 0; i < int'(rr.len); i++) begin
        if (rr.kind == CK_OUT || rr.kind == CK_BID) begin
          if (pos == c) k = rr.kind;
          if (pos + 1 == c) k = CK_CTL;
          pos += 2;
        end else begin
          if (pos == c) k = rr.kind;
          pos += 1;
        end
      end
    end
    return k;
  endfunction

  function automatic int chain_len();
    int pos;
    run_t rr;
    pos = 0;
    for (int r = 0; r < NUM_RUNS; r++) begin
      rr = run_at(r);
      if (rr.kind == CK_OUT || rr.kind == CK_BID) pos += 2 * int'(rr.len);
      else pos += int'(rr.len);
    end
    return pos;
  endfunction

  // Number of cells of kind k below position upto
  function automatic int count_kind(cell_kind_e k, int upto);
    int n;
    n = 0;
    for (int c = 0; c < upto; c++) begin
      if (kind_at(c) == k) n++;
    end
    return n;
  endfunction

  localparam int BSR_LEN   = chain_len();
  localparam int BSR_N_IN  = count_kind(CK_IN,  BSR_LEN);
  localparam int BSR_N_OUT = count_kind(CK_OUT, BSR_LEN);
  localparam int BSR_N_BID = count_kind(CK_BID, BSR_LEN);

endpackage

// File: rtl/bsr_cell.sv
module bsr_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic capture_i,
  input  logic shift_i,
  input  logic update_i,
  input  logic cap_i,
  input  logic si_i,
  output logic so_o,
  output logic upd_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        so_o <= RST_VAL;
    else if (capture_i) so_o <= cap_i;
    else if (shift_i)   so_o <= si_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       upd_o <= RST_VAL;
    else if (update_i) upd_o <= so_o;
  end

endmodule

// File: rtl/bsr_drive.sv
module bsr_drive (
  input  logic test_i,
  input  logic hiz_i,
  input  logic core_d_i,
  input  logic core_oe_i,
  input  logic upd_d_i,
  input  logic upd_dis_i,
  output logic pin_d_o,
  output logic pin_oe_o
);

  assign pin_d_o  = test_i ? upd_d_i : core_d_i;
  assign pin_oe_o = !hiz_i && (test_i ? !upd_dis_i : core_oe_i);

endmodule

// File: rtl/bsr_chain.sv
module bsr_chain
  import bsr_pkg::*;
(
  input  logic                 tck_i,
  input  logic                 rst_ni,
  input  logic                 capture_i,
  input  logic                 shift_i,
  input  logic                 update_i,
  input  logic                 test_mode_i,
  input  logic                 hiz_i,
  input  logic                 tdi_i,
  output logic                 tdo_o,
  input  logic [BSR_N_IN-1:0]  in_pin_i,
  output logic [BSR_N_IN-1:0]  in_core_o,
  input  logic [BSR_N_OUT-1:0] out_core_d_i,
  input  logic [BSR_N_OUT-1:0] out_core_oe_i,
  output logic [BSR_N_OUT-1:0] out_pin_d_o,
  output logic [BSR_N_OUT-1:0] out_pin_oe_o,
  input  logic [BSR_N_BID-1:0] bid_core_d_i,
  input  logic [BSR_N_BID-1:0] bid_core_oe_i,
  input  logic [BSR_N_BID-1:0] bid_pin_i,
  output logic [BSR_N_BID-1:0] bid_core_o,
  output logic [BSR_N_BID-1:0] bid_pin_d_o,
  output logic [BSR_N_BID-1:0] bid_pin_oe_o
);

  localparam int LEN = BSR_LEN;

  logic [LEN-1:0] sr_q;
  logic [LEN-1:0] upd_q;
  logic [LEN-1:0] cap_d;
  logic [LEN:0]   scan_w;
  logic           unused_upd;

  assign scan_w     = {tdi_i, sr_q};
  assign tdo_o      = sr_q[0];
  assign in_core_o  = in_pin_i;
  assign bid_core_o = bid_pin_i;
  assign unused_upd = ^upd_q;

  for (genvar c = 0; c < LEN; c++) begin : g_cell
    localparam cell_kind_e KIND = kind_at(c);
    localparam int         IDX  = count_kind(KIND, c);

    if (KIND == CK_IN) begin : g_in
      assign cap_d[c] = in_pin_i[IDX];
    end else if (KIND == CK_OUT) begin : g_out
      assign cap_d[c] = out_pin_d_o[IDX];
      bsr_drive u_drv (
        .test_i    (test_mode_i),
        .hiz_i     (hiz_i),
        .core_d_i  (out_core_d_i[IDX]),
        .core_oe_i (out_core_oe_i[IDX]),
        .upd_d_i   (upd_q[c]),
        .upd_dis_i (upd_q[c+1]),
        .pin_d_o   (out_pin_d_o[IDX]),
        .pin_oe_o  (out_pin_oe_o[IDX])
      );
    end else if (KIND == CK_BID) begin : g_bid
      assign cap_d[c] = bid_pin_i[IDX];
      bsr_drive u_drv (
        .test_i    (test_mode_i),
        .hiz_i     (hiz_i),
        .core_d_i  (bid_core_d_i[IDX]),
        .core_oe_i (bid_core_oe_i[IDX]),
        .upd_d_i   (upd_q[c]),
        .upd_dis_i (upd_q[c+1]),
        .pin_d_o   (bid_pin_d_o[IDX]),
        .pin_oe_o  (bid_pin_oe_o[IDX])
      );
    end else if (KIND == CK_CTL) begin : g_ctl
      localparam cell_kind_e OWNER = kind_at(c - 1);
      localparam int         OIDX  = count_kind(OWNER, c - 1);
      // Control reads the disable actually applied at the pin
      if (OWNER == CK_OUT) begin : g_o
        assign cap_d[c] = !out_pin_oe_o[OIDX];
      end else begin : g_b
        assign cap_d[c] = !bid_pin_oe_o[OIDX];
      end
    end else begin : g_int
      assign cap_d[c] = 1'b0;
    end

    bsr_cell #(.RST_VAL(KIND == CK_CTL)) u_cell (
      .clk_i     (tck_i),
      .rst_ni    (rst_ni),
      .capture_i (capture_i),
      .shift_i   (shift_i),
      .update_i  (update_i),
      .cap_i     (cap_d[c]),
      .si_i      (scan_w[c+1]),
      .so_o      (sr_q[c]),
      .upd_o     (upd_q[c])
    );
  end

endmodule

// File: rtl/bsr_chain_chk.sv
module bsr_chain_chk
  import bsr_pkg::*;
(
  input logic                 tck_i,
  input logic                 rst_ni,
  input logic                 capture_i,
  input logic                 shift_i,
  input logic                 update_i,
  input logic                 test_mode_i,
  input logic                 hiz_i,
  input logic                 tdo_o,
  input logic [BSR_LEN-1:0]   sr_q,
  input logic [BSR_N_OUT-1:0] out_pin_d_o,
  input logic [BSR_N_OUT-1:0] out_pin_oe_o,
  input logic [BSR_N_BID-1:0] bid_pin_d_o,
  input logic [BSR_N_BID-1:0] bid_pin_oe_o
);

  // R1
  shift_step_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    shift_i && !capture_i |=> tdo_o == $past(sr_q[1]));

  // R2
  internal_zero_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    capture_i |=> !tdo_o);

  // R9
  hiz_off_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    hiz_i |-> (out_pin_oe_o == '0) && (bid_pin_oe_o == '0));

  // R10
  pins_hold_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    test_mode_i && $past(test_mode_i) && !$past(update_i) && $stable(hiz_i)
    |-> $stable(out_pin_d_o) && $stable(out_pin_oe_o)
        && $stable(bid_pin_d_o) && $stable(bid_pin_oe_o));

  // R11
  reset_safe_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $rose(rst_ni) && test_mode_i |-> (out_pin_oe_o == '0) && (bid_pin_oe_o == '0)
                                     && (out_pin_d_o == '0) && (bid_pin_d_o == '0));

endmodule

bind bsr_chain bsr_chain_chk u_chk (
  .tck_i        (tck_i),
  .rst_ni       (rst_ni),
  .capture_i    (capture_i),
  .shift_i      (shift_i),
  .update_i     (update_i),
  .test_mode_i  (test_mode_i),
  .hiz_i        (hiz_i),
  .tdo_o        (tdo_o),
  .sr_q         (sr_q),
  .out_pin_d_o  (out_pin_d_o),
  .out_pin_oe_o (out_pin_oe_o),
  .bid_pin_d_o  (bid_pin_d_o),
  .bid_pin_oe_o (bid_pin_oe_o)
);

// File: tb/bsr_chain_tb_top.sv
module bsr_chain_tb_top;

  localparam int LEN = 65;
  localparam int NI  = 10;
  localparam int NO  = 8;
  localparam int NB  = 17;

  localparam int IN_POS  [NI] = '{1, 2, 14, 29, 30, 33, 44, 62, 63, 64};
  localparam int OUT_POS [NO] = '{3, 31, 35, 37, 40, 42, 56, 58};
  localparam int BID_POS [NB] = '{5, 7, 10, 12, 15, 17, 19, 21, 23, 25, 27, 45, 47, 49, 51, 53, 60};
  localparam int INT_POS [5]  = '{0, 9, 34, 39, 55};

  logic tck = 1'b0;
  logic rst_ni = 1'b0;
  logic capture = 1'b0, shift = 1'b0, update = 1'b0, test_mode = 1'b0, hiz = 1'b0, tdi = 1'b0;
  logic tdo;
  logic [NI-1:0] in_pin = '0, in_core;
  logic [NO-1:0] out_cd = '0, out_coe = '0, out_pd, out_poe;
  logic [NB-1:0] bid_cd = '0, bid_coe = '0, bid_pin = '0, bid_core, bid_pd, bid_poe;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 tck = ~tck;

  bsr_chain dut_i (
    .tck_i (tck), .rst_ni (rst_ni), .capture_i (capture), .shift_i (shift),
    .update_i (update), .test_mode_i (test_mode), .hiz_i (hiz), .tdi_i (tdi),
    .tdo_o (tdo), .in_pin_i (in_pin), .in_core_o (in_core),
    .out_core_d_i (out_cd), .out_core_oe_i (out_coe),
    .out_pin_d_o (out_pd), .out_pin_oe_o (out_poe),
    .bid_core_d_i (bid_cd), .bid_core_oe_i (bid_coe), .bid_pin_i (bid_pin),
    .bid_core_o (bid_core), .bid_pin_d_o (bid_pd), .bid_pin_oe_o (bid_poe)
  );

  task automatic chk(input bit ok, input string req, input logic [64:0] act, input logic [64:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  task automatic do_capture();
    capture = 1'b1; step(); capture = 1'b0; #1;
  endtask

  task automatic do_update();
    update = 1'b1; step(); update = 1'b0; #1;
  endtask

  task automatic scan(input logic [LEN-1:0] din, output logic [LEN-1:0] dout);
    shift = 1'b1;
    for (int i = 0; i < LEN; i++) begin
      dout[i] = tdo;
      tdi = din[i];
      step();
    end
    shift = 1'b0;
    #1;
  endtask

  function automatic logic [LEN-1:0] rand65();
    logic [95:0] r;
    r = {$urandom(), $urandom(), $urandom()};
    return r[LEN-1:0];
  endfunction

  function automatic logic [LEN-1:0] ctl_mask();
    logic [LEN-1:0] m;
    m = '0;
    for (int j = 0; j < NO; j++) m[OUT_POS[j]+1] = 1'b1;
    for (int j = 0; j < NB; j++) m[BID_POS[j]+1] = 1'b1;
    return m;
  endfunction

  // Pins expected in test mode from a loaded update word
  task automatic check_pins(input logic [LEN-1:0] p, input string req);
    logic [NO-1:0] eod, eoe;
    logic [NB-1:0] ebd, ebe;
    for (int j = 0; j < NO; j++) begin
      eod[j] = p[OUT_POS[j]];
      eoe[j] = !p[OUT_POS[j]+1];
    end
    for (int j = 0; j < NB; j++) begin
      ebd[j] = p[BID_POS[j]];
      ebe[j] = !p[BID_POS[j]+1];
    end
    chk(out_pd == eod && out_poe == eoe, req, 65'({out_pd, out_poe}), 65'({eod, eoe}));
    chk(bid_pd == ebd && bid_poe == ebe, req, 65'({bid_pd, bid_poe}), 65'({ebd, ebe}));
  endtask

  task automatic randomize_io();
    logic [31:0] r;
    r = $urandom(); in_pin  = r[NI-1:0];
    r = $urandom(); out_cd  = r[NO-1:0];
    r = $urandom(); out_coe = r[NO-1:0];
    r = $urandom(); bid_cd  = r[NB-1:0];
    r = $urandom(); bid_coe = r[NB-1:0];
    r = $urandom(); bid_pin = r[NB-1:0];
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge tck);
    n_fail++;
    $display("FAIL R1 watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [LEN-1:0] dout, dout2, p, prev, e, m;
    logic [NO-1:0] out_oe_exp;
    logic [NB-1:0] bid_oe_exp;

    // R11: pins in reset with test mode selected
    test_mode = 1'b1;
    step(); step();
    chk(out_poe == '0 && bid_poe == '0, "R11 oe in reset", 65'({out_poe, bid_poe}), 65'd0);
    chk(out_pd == '0 && bid_pd == '0, "R11 data in reset", 65'({out_pd, bid_pd}), 65'd0);
    chk(tdo == 1'b0, "R11 tdo in reset", 65'(tdo), 65'd0);
    rst_ni = 1'b1;
    step();
    scan('0, dout);
    chk(dout == ctl_mask(), "R11 capture stages after reset", dout, ctl_mask());
    chk(out_poe == '0 && bid_poe == '0, "R10 pins off during shift after reset", 65'({out_poe, bid_poe}), 65'd0);
    test_mode = 1'b0;

    // R7 R9 R3 R5: normal mode follows core
    for (int it = 0; it < 40; it++) begin
      randomize_io();
      hiz = (it % 4 == 3);
      #1;
      out_oe_exp = hiz ? '0 : out_coe;
      bid_oe_exp = hiz ? '0 : bid_coe;
      chk(out_pd == out_cd && bid_pd == bid_cd, "R7 data follows core", 65'({out_pd, bid_pd}), 65'({out_cd, bid_cd}));
      chk(out_poe == out_oe_exp, hiz ? "R9 out enables off" : "R7 out enables", 65'(out_poe), 65'(out_oe_exp));
      chk(bid_poe == bid_oe_exp, hiz ? "R9 bid enables off" : "R7 bid enables", 65'(bid_poe), 65'(bid_oe_exp));
      chk(in_core == in_pin, "R3 input pass-through", 65'(in_core), 65'(in_pin));
      chk(bid_core == bid_pin, "R5 bidir pass-through", 65'(bid_core), 65'(bid_pin));
    end
    hiz = 1'b0;

    // R1-family capture sweep in normal mode
    for (int it = 0; it < 24; it++) begin
      randomize_io();
      hiz = (it % 3 == 0);
      #1;
      do_capture();
      p = rand65();
      scan(p, dout);
      e = '0; m = '0;
      for (int j = 0; j < 5; j++) m[INT_POS[j]] = 1'b1;
      chk((dout & m) == e, "R2 internal cells capture 0", dout & m, e);
      e = '0; m = '0;
      for (int j = 0; j < NI; j++) begin m[IN_POS[j]] = 1'b1; e[IN_POS[j]] = in_pin[j]; end
      chk((dout & m) == e, "R3 input cells", dout & m, e);
      e = '0; m = '0;
      for (int j = 0; j < NO; j++) begin m[OUT_POS[j]] = 1'b1; e[OUT_POS[j]] = out_cd[j]; end
      chk((dout & m) == e, "R4 output cells", dout & m, e);
      e = '0; m = '0;
      for (int j = 0; j < NB; j++) begin m[BID_POS[j]] = 1'b1; e[BID_POS[j]] = bid_pin[j]; end
      chk((dout & m) == e, "R5 bidir cells", dout & m, e);
      e = '0; m = ctl_mask();
      for (int j = 0; j < NO; j++) e[OUT_POS[j]+1] = hiz | !out_coe[j];
      for (int j = 0; j < NB; j++) e[BID_POS[j]+1] = hiz | !bid_coe[j];
      chk((dout & m) == e, "R6 control cells", dout & m, e);
      scan('0, dout2);
      chk(dout2 == p, "R1 65-cell round trip", dout2, p);
    end
    hiz = 1'b0;

    // R8 R10 R9 R4 R6: test mode with update stages
    test_mode = 1'b1;
    #1;
    prev = ctl_mask();
    check_pins(prev, "R11 test mode after reset");
    for (int it = 0; it < 24; it++) begin
      p = rand65();
      scan(p, dout);
      if (it > 0) begin
        e = '0; m = '0;
        for (int j = 0; j < NO; j++) begin
          m[OUT_POS[j]] = 1'b1;   e[OUT_POS[j]]   = prev[OUT_POS[j]];
          m[OUT_POS[j]+1] = 1'b1; e[OUT_POS[j]+1] = prev[OUT_POS[j]+1];
        end
        chk((dout & m) == e, "R4 R6 capture of driven pins in test mode", dout & m, e);
      end
      check_pins(prev, "R10 pins hold through shift");
      do_update();
      check_pins(p, "R8 pins from update stages");
      hiz = 1'b1;
      #1;
      chk(out_poe == '0 && bid_poe == '0, "R9 hiz over test mode", 65'({out_poe, bid_poe}), 65'd0);
      hiz = 1'b0;
      #1;
      randomize_io();
      do_capture();
      check_pins(p, "R10 pins hold through capture");
      chk(in_core == in_pin && bid_core == bid_pin, "R3 R5 pass-through in test mode",
          65'({in_core, bid_core}), 65'({in_pin, bid_pin}));
      prev = p;
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule